// File: doc/BRIEF.md
# Serial Receive FIFO Status and Interrupt Unit

This block sits beside a byte-oriented serial port and gives a CPU a small register view of it. Bytes from a deserializer arrive on a valid/data strobe and are queued in an eight-entry receive FIFO. The CPU drains the FIFO through a data register. It reads a status word that reports transmit readiness, receive occupancy and a sticky overflow condition. The CPU also programs a 13-bit baud divider.

A single level-sensitive receive interrupt is raised from one of two sources, chosen by a mode bit in the status word. The first source is "at least one byte waiting". The second is "FIFO completely full", which suits packet-style draining of eight bytes at a time. The interrupt follows the FIFO occupancy register directly, so it changes in the same cycle as the occupancy does.

The CPU port is a simple synchronous one. Writes take effect at the clock edge. Read data is combinational from the address. A read strobe on the receive data address pops the FIFO at that edge. The address map is: 0 for status, 1 for the baud divider, 2 for receive data. Address 3 reads zero.

Top module: `serstat_top`

## Requirements
- R1: After reset the FIFO is empty, status bits 3..0 read 0, the interrupt is low and the baud register reads 0x0017.
- R2: Status bit 4 is read-only and always equals the `txNotFull` input.
- R3: Status bit 0 is read-only and reads 1 exactly when the receive FIFO holds one or more bytes.
- R4: Status bit 1 is read-only and reads 1 exactly when the receive FIFO holds eight bytes.
- R5: A byte that arrives while the FIFO is full and not being popped is discarded. The queued bytes are unchanged and status bit 2 is set.
- R6: Status bit 2 stays set until the CPU writes status with bit 2 = 1. Writing bit 2 = 0 leaves it unchanged.
- R7: Status bit 3 is a read/write mode bit that resets to 0. Writes to status bits 0, 1 and 4 have no effect.
- R8: `rxIrq` equals status bit 1 when bit 3 is 1, and status bit 0 when bit 3 is 0.
- R9: A read at address 2 returns the oldest queued byte in bits 7..0, with bits 15..8 zero. The same read removes that byte, and bytes leave in arrival order.
- R10: A read at address 2 while the FIFO is empty returns 0 and changes no state.
- R11: At address 1, bits 12..0 are read/write. Bits 15..13 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive byte strobe from deserializer |
| rxByte | input | 8 | Received byte |
| txNotFull | input | 1 | Transmit FIFO can accept a byte |
| cpuAddr | input | 2 | Register address |
| cpuWrEn | input | 1 | Register write strobe |
| cpuRdEn | input | 1 | Register read strobe (pops at address 2) |
| cpuWrData | input | 16 | Write data |
| cpuRdData | output | 16 | Read data (combinational) |
| rxIrq | output | 1 | Receive interrupt, level |

## Verification
The bench builds the block with its default parameters: an 8-entry, 8-bit FIFO and a 13-bit baud field with reset value 0x0017. With a depth of eight, the full flag, the packet-mode interrupt and the overflow discard are all reached with short directed push sequences. Draining the FIFO afterwards confirms that a dropped byte never displaced queued data and that ordering held across pointer wrap.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BAUD   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RXDATA = 2'd2;

  localparam int BIT_RXRDY  = 0;
  localparam int BIT_PKTRDY = 1;
  localparam int BIT_OVF    = 2;
  localparam int BIT_MODE   = 3;
  localparam int BIT_TXRDY  = 4;

  typedef struct packed {
    logic statWr;
    logic baudWr;
    logic popReq;
  } strobe_t;
endpackage

// File: rtl/serstat_dp.sv
module serstat_dp
  import serstat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 8,
  parameter int BAUD_W = 13,
  parameter logic [BAUD_W-1:0] BAUD_RST = 13'h0017
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] headByte,
  output logic              rxRdy,
  output logic              pktRdy,
  output logic              ovfFlag,
  output logic              modeBit,
  output logic [BAUD_W-1:0] baudVal,
  output logic              rxIrq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic full, empty, doPush, doPop, ovfSet, ovfClr;

  assign full   = (count == CNT_FULL);
  assign empty  = (count == '0);
  assign doPop  = strobes.popReq && !empty;
  assign doPush = rxValid && (!full || doPop);
  assign ovfSet = rxValid && full && !doPop;
  assign ovfClr = strobes.statWr && wrData[BIT_OVF];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      modeBit <= 1'b0;
      baudVal <= BAUD_RST;
    end else begin
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
      if (strobes.statWr) modeBit <= wrData[BIT_MODE];
      if (strobes.baudWr) baudVal <= wrData[BAUD_W-1:0];
    end
  end

  assign headByte = empty ? '0 : mem[rdPtr];
  assign rxRdy    = !empty;
  assign pktRdy   = full;
  assign rxIrq    = modeBit ? pktRdy : rxRdy;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);                                               // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && full && !strobes.popReq) |=> (count == CNT_FULL && ovfFlag)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(strobes.statWr && wrData[BIT_OVF])) |=> ovfFlag);   // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (empty && strobes.popReq && !rxValid) |=> (count == '0));         // R10
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (count != '0));                                         // R8
endmodule

// File: rtl/serstat_ctrl.sv
module serstat_ctrl
  import serstat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic              txNotFull,
  input  logic [DATA_W-1:0] headByte,
  input  logic              rxRdy,
  input  logic              pktRdy,
  input  logic              ovfFlag,
  input  logic              modeBit,
  input  logic [BAUD_W-1:0] baudVal,
  output strobe_t           strobes,
  output logic [REG_W-1:0]  rdData
);
  logic [REG_W-1:0] statusWord;

  always_comb begin
    strobes        = '0;
    strobes.statWr = cpuWrEn && (cpuAddr == ADDR_STATUS);
    strobes.baudWr = cpuWrEn && (cpuAddr == ADDR_BAUD);
    strobes.popReq = cpuRdEn && (cpuAddr == ADDR_RXDATA);
  end

  always_comb begin
    statusWord             = '0;
    statusWord[BIT_RXRDY]  = rxRdy;
    statusWord[BIT_PKTRDY] = pktRdy;
    statusWord[BIT_OVF]    = ovfFlag;
    statusWord[BIT_MODE]   = modeBit;
    statusWord[BIT_TXRDY]  = txNotFull;
  end

  always_comb begin
    case (cpuAddr)
      ADDR_STATUS: rdData = statusWord;
      ADDR_BAUD:   rdData = REG_W'(baudVal);
      ADDR_RXDATA: rdData = REG_W'(headByte);
      default:     rdData = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.statWr, strobes.baudWr, strobes.popReq}));      // R7
endmodule

// File: rtl/serstat_top.sv
module serstat_top
  import serstat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = 8,
  parameter int BAUD_W = 13,
  parameter logic [BAUD_W-1:0] BAUD_RST = 13'h0017
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txNotFull,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [REG_W-1:0]  cpuWrData,
  output logic [REG_W-1:0]  cpuRdData,
  output logic              rxIrq
);
  strobe_t           strobes;
  logic [DATA_W-1:0] headByte;
  logic              rxRdy, pktRdy, ovfFlag, modeBit;
  logic [BAUD_W-1:0] baudVal;

  serstat_ctrl #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn),
    .cpuRdEn(cpuRdEn), .txNotFull(txNotFull), .headByte(headByte),
    .rxRdy(rxRdy), .pktRdy(pktRdy), .ovfFlag(ovfFlag), .modeBit(modeBit),
    .baudVal(baudVal), .strobes(strobes), .rdData(cpuRdData)
  );

  serstat_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BAUD_W(BAUD_W),
               .BAUD_RST(BAUD_RST)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(cpuWrData),
    .rxValid(rxValid), .rxByte(rxByte), .headByte(headByte),
    .rxRdy(rxRdy), .pktRdy(pktRdy), .ovfFlag(ovfFlag), .modeBit(modeBit),
    .baudVal(baudVal), .rxIrq(rxIrq)
  );

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWrEn && cpuAddr == ADDR_STATUS) |=> $stable(modeBit));       // R7
endmodule

// File: tb/serstat_top_test.sv
`timescale 1ns/1ps
module serstat_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txNotFull = 1'b0;
  logic [1:0]  cpuAddr = '0;
  logic        cpuWrEn = 1'b0;
  logic        cpuRdEn = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic [15:0] cpuRdData;
  logic        rxIrq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  serstat_top uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .txNotFull(txNotFull), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn),
    .cpuRdEn(cpuRdEn), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .rxIrq(rxIrq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRdEn = 1'b1;
    #1 d = cpuRdData;
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cpuAddr = a;
    #1 d = cpuRdData;
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset;
    logic [15:0] d;
    txNotFull = 1'b0;
    doReset();
    peek(2'd0, d); check("R1 status", d, 16'h0000);
    check("R1 irq", {15'b0, rxIrq}, 16'h0);
    peek(2'd1, d); check("R1 baud", d, 16'h0017);
  endtask

  task automatic tTxReady;
    logic [15:0] d;
    txNotFull = 1'b1;
    peek(2'd0, d); check("R2 txrdy=1", d, 16'h0010);
    regWrite(2'd0, 16'h0000);
    peek(2'd0, d); check("R2 write ignored", d, 16'h0010);
    txNotFull = 1'b0;
    peek(2'd0, d); check("R2 txrdy=0", d, 16'h0000);
  endtask

  task automatic tFillOrder;
    logic [15:0] d;
    doReset();
    pushByte(8'hA0);
    peek(2'd0, d); check("R3 one byte", d, 16'h0001);
    check("R8 irq mode0", {15'b0, rxIrq}, 16'h1);
    for (int i = 1; i < 7; i++) pushByte(8'hA0 + 8'(i));
    peek(2'd0, d); check("R4 seven not full", d, 16'h0001);
    pushByte(8'hA7);
    peek(2'd0, d); check("R4 full", d, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      regRead(2'd2, d); check("R9 order", d, 16'h00A0 + 16'(i));
    end
    peek(2'd0, d); check("R3 drained", d, 16'h0000);
    for (int i = 0; i < 3; i++) pushByte(8'h50 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      regRead(2'd2, d); check("R9 wrap order", d, 16'h0050 + 16'(i));
    end
  endtask

  task automatic tOverflow;
    logic [15:0] d;
    doReset();
    for (int i = 0; i < 8; i++) pushByte(8'h10 + 8'(i));
    pushByte(8'hEE);
    peek(2'd0, d); check("R5 ovf set", d, 16'h0007);
    regWrite(2'd0, 16'h0000);
    peek(2'd0, d); check("R6 write0 keeps ovf", d, 16'h0007);
    regWrite(2'd0, 16'h0013);
    peek(2'd0, d); check("R7 ro bits unaffected", d, 16'h0007);
    regWrite(2'd0, 16'h0004);
    peek(2'd0, d); check("R6 write1 clears", d, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      regRead(2'd2, d); check("R5 contents kept", d, 16'h0010 + 16'(i));
    end
    peek(2'd0, d); check("R5 dropped byte absent", d, 16'h0000);
  endtask

  task automatic tMode;
    logic [15:0] d;
    doReset();
    regWrite(2'd0, 16'h0008);
    peek(2'd0, d); check("R7 mode set", d, 16'h0008);
    pushByte(8'h01);
    check("R8 mode1 partial low", {15'b0, rxIrq}, 16'h0);
    for (int i = 1; i < 8; i++) pushByte(8'(i));
    check("R8 mode1 full high", {15'b0, rxIrq}, 16'h1);
    regRead(2'd2, d);
    check("R8 mode1 drops after pop", {15'b0, rxIrq}, 16'h0);
    regWrite(2'd0, 16'h0000);
    check("R8 mode0 irq", {15'b0, rxIrq}, 16'h1);
  endtask

  task automatic tEmptyRead;
    logic [15:0] d;
    doReset();
    regRead(2'd2, d); check("R10 empty read zero", d, 16'h0000);
    peek(2'd0, d); check("R10 no state change", d, 16'h0000);
    pushByte(8'h3C);
    regRead(2'd2, d); check("R10 next byte intact", d, 16'h003C);
  endtask

  task automatic tBaud;
    logic [15:0] d;
    regWrite(2'd1, 16'hFFFF);
    peek(2'd1, d); check("R11 reserved zero", d, 16'h1FFF);
    regWrite(2'd1, 16'h0A5A);
    peek(2'd1, d); check("R11 write value", d, 16'h0A5A);
    peek(2'd3, d); check("R11 unmapped zero", d, 16'h0000);
  endtask

  initial begin
    fork
      begin
        tReset();
        tTxReady();
        tFillOrder();
        tOverflow();
        tMode();
        tEmptyRead();
        tBaud();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule